// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is the inner-product engine of an integer inference datapath. Each 32-bit lane carries four 8-bit activations and four signed 8-bit weights. It forms the four byte products, adds them, and folds the total into a signed 32-bit running sum in one pipelined operation. The usual three-step chain (byte pairs into 16 bits, then 16-bit pairs into 32 bits, then the accumulator add) becomes a single transfer, and the 16-bit intermediate is not modelled.

The multiplier array only handles unsigned activations times signed weights. When the mode input selects signed activations, each activation byte is moved into the unsigned range by adding 128, which flips its top bit. In the same cycle, the sum of that lane's four weights is formed. In the second stage, 128 times that weight sum is removed, so the stored value equals a true signed-by-signed dot product. A zero activation, such as a padded border position, becomes 128 after the shift, so it receives the same correction as any other element and still contributes nothing.

Operands enter and results leave through valid/ready handshakes. Two register stages give a fixed latency of two cycles and one result per cycle while the output side keeps accepting. The lane count is a parameter, and every lane is computed independently.

Top module: `bdot_acc`

## Requirements
- R1: With `mode_i` = 0, each activation byte is unsigned and each weight byte is signed. A lane's result is its accumulator word plus the sum of the four products, taken modulo 2^32.
- R2: With `mode_i` = 1, each activation byte is read as signed two's complement. A lane's result equals its accumulator word plus the signed-by-signed dot product, modulo 2^32.
- R3: In signed mode, a zero activation contributes nothing whatever its weight. With all four activations zero, the result equals the accumulator word.
- R4: The accumulation wraps modulo 2^32 in both directions, with no saturation.
- R5: An operand set taken on a rising edge (in_valid_i and in_ready_o both high) appears on result_o with out_valid_o high after the second rising edge counted from that one. out_valid_o is still low after the first.
- R6: With in_valid_i and out_ready_i held high, the block takes one operand set and delivers one result on every cycle, in arrival order.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and result_o does not change. Once both stages hold data, in_ready_o is low.
- R8: Lane l occupies bits [32*l +: 32] of act_i, wgt_i, acc_i and result_o. Byte k of a lane occupies bits [8*k +: 8] of that lane. Lanes never affect each other.
- R9: While reset is held and until it has been released, out_valid_o is low. After release, in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Operand set is present |
| in_ready_o | output | 1 | Block takes the operand set on this edge |
| act_i | input | 32*LANES | Packed activation bytes |
| wgt_i | input | 32*LANES | Packed signed weight bytes |
| acc_i | input | 32*LANES | Accumulator word for each lane |
| mode_i | input | 1 | 0: unsigned activations, 1: signed activations |
| out_valid_o | output | 1 | result_o holds a finished result |
| out_ready_i | input | 1 | Consumer takes the result on this edge |
| result_o | output | 32*LANES | Updated accumulator word for each lane |

## Verification
Several properties are checked on every cycle, under any traffic:
- An accepted operand set always reaches the first stage.
- An occupied first stage always moves on when the output is free.
- A stalled result holds both its valid flag and its value.
- After correction, the signed-mode product sum always stays within the range of a four-term signed byte dot product.

The arithmetic itself can only be shown by the bench scenarios. These compare each delivered word against an independent model for both modes. They include the border cases:
- padded zero activations;
- extreme activation and weight bytes;
- accumulator words at the wrap points;
- lanes holding very different data.

The same applies to the exact two-cycle latency and the full-rate stream.

// File: rtl/bdot_pkg.sv
package bdot_pkg;
  localparam int unsigned ELEM_W  = 8;
  localparam int unsigned ELEMS   = 4;
  localparam int unsigned LANE_W  = ELEM_W * ELEMS;
  localparam int unsigned ACC_W   = 32;
  localparam int unsigned PROD_W  = 2 * ELEM_W + 1;
  localparam int unsigned SUM_W   = PROD_W + $clog2(ELEMS);
  localparam int unsigned WSUM_W  = ELEM_W + $clog2(ELEMS);
  localparam int unsigned BIAS_SH = ELEM_W - 1;

  typedef enum logic {
    ACT_UNSIGNED = 1'b0,
    ACT_SIGNED   = 1'b1
  } act_mode_e;
endpackage

// File: rtl/bdot_lane_mac.sv
// First-stage arithmetic of one lane: offset activations when signed,
// form the unsigned-by-signed products, their sum, and the weight sum.
module bdot_lane_mac
  import bdot_pkg::*;
#(
  parameter int unsigned EW = ELEM_W,
  parameter int unsigned NE = ELEMS,
  localparam int unsigned PW  = 2 * EW + 1,
  localparam int unsigned SW  = PW + $clog2(NE),
  localparam int unsigned WSW = EW + $clog2(NE)
) (
  input  logic [NE*EW-1:0]     act_i,
  input  logic [NE*EW-1:0]     wgt_i,
  input  act_mode_e            mode_i,
  output logic signed [SW-1:0]  psum_o,
  output logic signed [WSW-1:0] wsum_o
);

  logic signed [PW-1:0] prod [NE];
  logic signed [PW-1:0] wgt_x [NE];

  for (genvar e = 0; e < NE; e++) begin : g_elem
    logic [EW-1:0]        act_u;
    logic signed [PW-1:0] act_x;
    // Adding 128 to a signed byte equals flipping its top bit.
    assign act_u    = {act_i[e*EW+EW-1] ^ (mode_i == ACT_SIGNED), act_i[e*EW +: EW-1]};
    assign act_x    = PW'($signed({1'b0, act_u}));
    assign wgt_x[e] = PW'($signed(wgt_i[e*EW +: EW]));
    assign prod[e]  = act_x * wgt_x[e];
  end

  always_comb begin
    psum_o = '0;
    wsum_o = '0;
    for (int e = 0; e < NE; e++) begin
      psum_o = psum_o + SW'(prod[e]);
      wsum_o = wsum_o + WSW'(wgt_x[e]);
    end
  end

endmodule

// File: rtl/bdot_lane_fix.sv
// Second-stage arithmetic of one lane: remove the offset term, then add
// into the accumulator word with modulo-2^32 wrap.
module bdot_lane_fix
  import bdot_pkg::*;
#(
  parameter int unsigned SW  = SUM_W,
  parameter int unsigned WSW = WSUM_W,
  parameter int unsigned AW  = ACC_W,
  parameter int unsigned SH  = BIAS_SH
) (
  input  logic signed [SW-1:0]  psum_i,
  input  logic signed [WSW-1:0] wsum_i,
  input  logic [AW-1:0]         acc_i,
  input  act_mode_e             mode_i,
  output logic [AW-1:0]         res_o
);

  logic [AW-1:0] psum_x;
  logic [AW-1:0] comp_x;

  always_comb begin
    psum_x = AW'(psum_i);
    comp_x = (mode_i == ACT_SIGNED) ? (AW'(wsum_i) << SH) : '0;
    res_o  = acc_i + psum_x - comp_x;
  end

endmodule

// File: rtl/bdot_flow.sv
// Handshake and stage-valid control for the two-stage pipeline, with the
// reset release synchroniser.
module bdot_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid_i,
  input  logic out_ready_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic s1_valid_o,
  output logic ld1_o,
  output logic ld2_o,
  output logic srst_n_o
);

  logic [1:0] sync_q;
  logic       v1_q, v1_d;
  logic       v2_q, v2_d;
  logic       adv1, adv2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n_o = sync_q[1];

  always_comb begin
    adv2  = !v2_q || out_ready_i;
    adv1  = (!v1_q || adv2) && srst_n_o;
    v1_d  = adv1 ? in_valid_i : v1_q;
    v2_d  = adv2 ? v1_q : v2_q;
    ld1_o = adv1 && in_valid_i;
    ld2_o = adv2 && v1_q;
  end

  always_ff @(posedge clk or negedge srst_n_o) begin
    if (!srst_n_o) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  assign in_ready_o  = adv1;
  assign out_valid_o = v2_q;
  assign s1_valid_o  = v1_q;

  AST_TAKE_FILLS_S1: assert property (@(posedge clk) disable iff (!srst_n_o)
    in_valid_i && in_ready_o |=> s1_valid_o); // R5
  AST_S1_MOVES_ON: assert property (@(posedge clk) disable iff (!srst_n_o)
    s1_valid_o && (!out_valid_o || out_ready_i) |=> out_valid_o); // R6
  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!srst_n_o)
    out_valid_o && !out_ready_i |=> out_valid_o); // R7

endmodule

// File: rtl/bdot_acc.sv
module bdot_acc
  import bdot_pkg::*;
#(
  parameter int unsigned LANES = 1,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [VEC_W-1:0] act_i,
  input  logic [VEC_W-1:0] wgt_i,
  input  logic [VEC_W-1:0] acc_i,
  input  logic             mode_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [VEC_W-1:0] result_o
);

  localparam int signed BOUND = ELEMS * (1 << (2 * BIAS_SH));

  logic s1_valid, ld1, ld2, srst_n;

  bdot_flow u_flow (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .s1_valid_o  (s1_valid),
    .ld1_o       (ld1),
    .ld2_o       (ld2),
    .srst_n_o    (srst_n)
  );

  act_mode_e        mode_d, mode_q;
  logic [VEC_W-1:0] acc_d, acc_q;
  logic [VEC_W-1:0] res_d, res_q;

  always_comb begin
    mode_d = act_mode_e'(mode_i);
    acc_d  = acc_i;
  end

  always_ff @(posedge clk) begin
    if (ld1) begin
      mode_q <= mode_d;
      acc_q  <= acc_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [SUM_W-1:0]  psum_d, psum_q;
    logic signed [WSUM_W-1:0] wsum_d, wsum_q;
    logic signed [ACC_W-1:0]  corr;

    bdot_lane_mac u_mac (
      .act_i  (act_i[l*LANE_W +: LANE_W]),
      .wgt_i  (wgt_i[l*LANE_W +: LANE_W]),
      .mode_i (mode_d),
      .psum_o (psum_d),
      .wsum_o (wsum_d)
    );

    always_ff @(posedge clk) begin
      if (ld1) begin
        psum_q <= psum_d;
        wsum_q <= wsum_d;
      end
    end

    bdot_lane_fix u_fix (
      .psum_i (psum_q),
      .wsum_i (wsum_q),
      .acc_i  (acc_q[l*ACC_W +: ACC_W]),
      .mode_i (mode_q),
      .res_o  (res_d[l*ACC_W +: ACC_W])
    );

    assign corr = ACC_W'(psum_q) - (ACC_W'(wsum_q) <<< BIAS_SH);

    AST_SIGNED_RANGE: assert property (@(posedge clk) disable iff (!srst_n)
      s1_valid && mode_q == ACT_SIGNED |-> (corr <= BOUND) && (corr >= -BOUND)); // R2
  end

  always_ff @(posedge clk) begin
    if (ld2) res_q <= res_d;
  end

  assign result_o = res_q;

  AST_STALL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid_o && !out_ready_i |=> $stable(result_o)); // R7

endmodule

// File: tb/bdot_acc_test.sv
module bdot_acc_test;
  localparam int LANES = 2;
  localparam int W = 32 * LANES;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_ready, mode, out_valid, out_ready;
  logic [W-1:0] act, wgt, acc, result;

  bdot_acc #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .act_i(act), .wgt_i(wgt), .acc_i(acc), .mode_i(mode),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .result_o(result)
  );

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";
  logic [W-1:0] expq[$];
  string tagq[$];

  function automatic logic [31:0] ref_lane(logic [31:0] a, logic [31:0] w, logic [31:0] c, logic sm);
    int s = int'(c);
    for (int k = 0; k < 4; k++) begin
      int av = sm ? int'($signed(a[k*8 +: 8])) : int'(a[k*8 +: 8]);
      s += av * int'($signed(w[k*8 +: 8]));
    end
    return 32'(s);
  endfunction

  function automatic logic [W-1:0] ref_word(logic [W-1:0] a, logic [W-1:0] w, logic [W-1:0] c, logic sm);
    logic [W-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*32 +: 32] = ref_lane(a[l*32 +: 32], w[l*32 +: 32], c[l*32 +: 32], sm);
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] actual, logic [W-1:0] expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Inputs are set just after a falling edge; sample 1 ns later, then wait.
  task automatic tick();
    #1;
    if (in_valid && in_ready) begin
      expq.push_back(ref_word(act, wgt, acc, mode));
      tagq.push_back(tag);
    end
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check(1'b0, "R6", result, '0);
      else begin
        logic [W-1:0] e = expq.pop_front();
        string t = tagq.pop_front();
        check(result === e, t, result, e);
      end
    end
    @(negedge clk);
  endtask

  task automatic rnd_ops();
    act = {$urandom(), $urandom()};
    wgt = {$urandom(), $urandom()};
    acc = {$urandom(), $urandom()};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; mode = 1'b0;
    act = '0; wgt = '0; acc = '0;
    repeat (3) @(negedge clk);
    #1 check(out_valid === 1'b0, "R9", W'(out_valid), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check(out_valid === 1'b0 && in_ready === 1'b1, "R9", W'({out_valid, in_ready}), W'(1));

    // R5: exact latency of two edges
    out_ready = 1'b1; tag = "R5"; rnd_ops(); in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    #1 check(out_valid === 1'b0, "R5", W'(out_valid), '0);
    tick();
    #1 check(out_valid === 1'b1, "R5", W'(out_valid), W'(1));
    tick();

    // R4: wrap upward and downward
    tag = "R4"; mode = 1'b0; in_valid = 1'b1;
    act = {2{32'hFFFF_FFFF}}; wgt = {2{32'h7F7F_7F7F}}; acc = {2{32'h7FFF_FFFF}};
    tick();
    act = {2{32'hFFFF_FFFF}}; wgt = {2{32'h8080_8080}}; acc = {2{32'h8000_0000}};
    tick();
    mode = 1'b1; act = {2{32'h8080_8080}}; wgt = {2{32'h8080_8080}}; acc = {2{32'h7FFF_FFFF}};
    tag = "R2"; tick();

    // R3: padded zero activations in signed mode
    tag = "R3"; act = '0; rnd_ops(); act = '0;
    tick();
    in_valid = 1'b0; tick(); tick();
    check(result === acc, "R3", result, acc);

    // R8: lanes with very different data
    tag = "R8"; in_valid = 1'b1; mode = 1'b0;
    act = {32'h0000_0000, 32'hFFFF_FFFF}; wgt = {32'h8080_8080, 32'h7F7F_7F7F};
    acc = {32'h1234_5678, 32'h0000_0000};
    tick();
    act = {32'hFF01_80FE, 32'h0000_0000}; wgt = {32'h0000_0000, 32'hFFFF_FFFF};
    tick();

    // R7: stall fills both stages, output held
    in_valid = 1'b1; out_ready = 1'b0; tag = "R7"; rnd_ops();
    tick(); rnd_ops(); tick(); rnd_ops(); tick();
    #1 check(in_ready === 1'b0, "R7", W'(in_ready), '0);
    check(out_valid === 1'b1, "R7", W'(out_valid), W'(1));
    held = result;
    in_valid = 1'b0;
    tick(); tick();
    #1 check(result === held && out_valid === 1'b1, "R7", result, held);
    out_ready = 1'b1;
    repeat (4) tick();

    // R6: full-rate stream
    tag = "R6"; in_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      rnd_ops(); mode = 1'(i % 2);
      #1 check(in_ready === 1'b1, "R6", W'(in_ready), W'(1));
      if (i >= 2) check(out_valid === 1'b1, "R6", W'(out_valid), W'(1));
      tick();
    end
    in_valid = 1'b0;
    repeat (3) tick();

    // R1/R2: random traffic
    for (int i = 0; i < 600; i++) begin
      rnd_ops();
      mode = 1'($urandom_range(0, 1));
      tag = mode ? "R2" : "R1";
      in_valid = ($urandom_range(0, 9) < 7);
      out_ready = ($urandom_range(0, 9) < 7);
      tick();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) tick();
    check(expq.size() == 0, "R6", W'(expq.size()), '0);
    summary();
    $finish;
  end
endmodule